// File: doc/BRIEF.md
# Multichannel Sensor Front-End Command Controller

This block holds the control state of an eight-channel bridge-sensor front end and turns the commands from its serial host interface into static analog control levels. Each command arrives as one transfer of an 8-bit sub-address together with a 16-bit parameter word. The block updates its gain, regulator, channel and per-channel offset settings from these commands. It also tracks the active, sleep and current-sense modes.

The outputs drive the analog section directly: a channel index, a gain code, the offset code of the selected channel, the regulator voltage select and enable, the output-path select and the analog power-down. A combinational read port gives the identity word, the version word and every stored setting for any address the host reads.

The command input follows valid/ready rules. `cmd_ready` is held high, so the block never applies back-pressure. A transfer happens on every rising edge where `cmd_valid` is high, and the host may present one command per cycle. Commands that are not recognised, or that the current mode does not allow, are still accepted but have no effect. Outputs change on the clock edge that accepts the command.

Top module: `afe_cmd_ctrl`

## Requirements
- R1: After reset the outputs are: channel index 0 (the first channel), gain code 0, regulator select 0, regulator enable 1, sense select 0, power-down 0 and offset code 0. Every stored offset is 0 and the regulator register reads 0.
- R2: A command with sub-address 0x10, 0x12, 0x14, 0x15, 0x18, 0x1A, 0x1C or 0x1E selects channel index 0 to 7, in that order, and ignores its parameter word. Other sub-addresses in this range, such as 0x11 or 0x16, change nothing.
- R3: A command at sub-address 0x20, 0x22, 0x24, 0x25, 0x28, 0x2A, 0x2C or 0x2E stores parameter bits 10:0 as the offset of channel index 0 to 7. Bit 10 is the sign, where 1 means negative, and bits 9:0 are the magnitude. Higher parameter bits are dropped. Reading the same address returns the stored 11 bits, zero-extended.
- R4: `ofs_code` always shows the stored offset of the channel named by `ch_sel` and no other.
- R5: Sub-address 0x06 stores parameter bits 2:0 as the gain code. Reading 0x06 returns that code, zero-extended.
- R6: Sub-address 0x07 stores bit 0 (regulator select, driven on `ldo_sel`) and bit 1 (switch off the regulator in sleep). Reading 0x07 returns these two bits. `ldo_en` is 1 while active. In sleep, `ldo_en` is the inverse of bit 1.
- R7: Sub-address 0x05 enters sleep and raises `pwr_down`. While asleep, only 0x04 (which returns to active) and 0x07 take effect. Every other command is ignored. All settings stay as they were and remain readable.
- R8: Sub-address 0x08, while active, raises `sense_sel`. It stays high until a channel-select command is accepted while active. A channel-select command received in sleep does not clear it.
- R9: Reading 0x02 returns 0x8910. Reading 0x03 returns 0x0001 (bits 15:12 zero, hardware revision 0 in bits 11:8, software revision 1 in bits 7:0). Any address that stores nothing reads 0.
- R10: Sub-address 0x01, while active, restores every R1 value, including all eight offsets.
- R11: `cmd_ready` is always 1. Read data reflects the settings held before any command accepted in the same cycle.
- R12: Sub-address 0x00, and a cycle with `cmd_valid` low, change no output and no readable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command transfer request |
| cmd_ready | output | 1 | Command accept, held high |
| cmd_addr | input | 8 | Command sub-address |
| cmd_data | input | 16 | Command parameter word |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| ch_sel | output | 3 | Selected input channel index |
| gain_code | output | 3 | Amplifier gain code |
| ofs_code | output | 11 | Sign-magnitude offset of the selected channel |
| ldo_sel | output | 1 | Regulator voltage select |
| ldo_en | output | 1 | Regulator enable |
| sense_sel | output | 1 | Output path switched to regulator current sense |
| pwr_down | output | 1 | Analog power-down (sleep) |

## Verification
A read and a command that writes the same setting can arrive in the same cycle. The bench provokes this by presenting a gain write and a read of address 0x06 together. It samples `rd_data` just after the drive point, where the old code is expected, and again after the accepting edge, where the new code is expected. Two pairs of functions also meet in one cycle and are checked: a channel select against current-sense mode, and every blocked sub-address against sleep. In each case the bench compares all outputs against its own model of the register state, and sweeps all 256 read addresses while the block is asleep.

// File: rtl/afe_cmd_pkg.sv
package afe_cmd_pkg;
  localparam int NUM_CH = 8;
  localparam int CH_W   = $clog2(NUM_CH);

  localparam logic [7:0] SA_NOP    = 8'h00;
  localparam logic [7:0] SA_RESET  = 8'h01;
  localparam logic [7:0] SA_ID     = 8'h02;
  localparam logic [7:0] SA_VER    = 8'h03;
  localparam logic [7:0] SA_WAKE   = 8'h04;
  localparam logic [7:0] SA_SLEEP  = 8'h05;
  localparam logic [7:0] SA_GAIN   = 8'h06;
  localparam logic [7:0] SA_LDO    = 8'h07;
  localparam logic [7:0] SA_SENSE  = 8'h08;
  localparam logic [7:0] OFS_SHIFT = 8'h10;

  localparam logic [15:0] ID_WORD = 16'h8910;
  localparam logic [3:0]  HW_REV  = 4'h0;
  localparam logic [7:0]  SW_REV  = 8'h01;

  // channel-select sub-address per channel index (irregular spacing)
  function automatic logic [7:0] chan_code(input int unsigned idx);
    case (idx)
      0: chan_code = 8'h10;
      1: chan_code = 8'h12;
      2: chan_code = 8'h14;
      3: chan_code = 8'h15;
      4: chan_code = 8'h18;
      5: chan_code = 8'h1A;
      6: chan_code = 8'h1C;
      7: chan_code = 8'h1E;
      default: chan_code = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] ofs_code_addr(input int unsigned idx);
    ofs_code_addr = chan_code(idx) + OFS_SHIFT;
  endfunction

  typedef enum logic [3:0] {
    OP_NONE, OP_RESET, OP_WAKE, OP_SLEEP, OP_GAIN,
    OP_LDO, OP_SENSE, OP_CHAN, OP_OFS
  } op_e;

  typedef struct packed {
    op_e             op;
    logic [CH_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/afe_cmd_decode.sv
module afe_cmd_decode
  import afe_cmd_pkg::*;
(
  input  logic       cmd_fire,
  input  logic [7:0] cmd_addr,
  input  logic       asleep,
  output cmd_t       dec
);
  logic [NUM_CH-1:0] hit_sel;
  logic [NUM_CH-1:0] hit_ofs;
  cmd_t              raw;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_match
      assign hit_sel[g] = (cmd_addr == chan_code(g));
      assign hit_ofs[g] = (cmd_addr == ofs_code_addr(g));
    end
  endgenerate

  always_comb begin
    raw.op  = OP_NONE;
    raw.idx = '0;
    case (cmd_addr)
      SA_RESET: raw.op = OP_RESET;
      SA_WAKE:  raw.op = OP_WAKE;
      SA_SLEEP: raw.op = OP_SLEEP;
      SA_GAIN:  raw.op = OP_GAIN;
      SA_LDO:   raw.op = OP_LDO;
      SA_SENSE: raw.op = OP_SENSE;
      default:  raw.op = OP_NONE;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_sel[i]) begin
        raw.op  = OP_CHAN;
        raw.idx = CH_W'(i);
      end
      if (hit_ofs[i]) begin
        raw.op  = OP_OFS;
        raw.idx = CH_W'(i);
      end
    end
  end

  // sleep filter: only wake and regulator settings pass
  always_comb begin
    dec = raw;
    if (!cmd_fire)
      dec.op = OP_NONE;
    else if (asleep && raw.op != OP_WAKE && raw.op != OP_LDO)
      dec.op = OP_NONE;
  end
endmodule

// File: rtl/afe_mode_fsm.sv
module afe_mode_fsm
  import afe_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  output logic asleep,
  output logic sense_on
);
  typedef enum logic {MODE_RUN, MODE_NAP} mode_e;

  mode_e mode_q, mode_d;
  logic  sense_q, sense_d;

  always_comb begin
    mode_d  = mode_q;
    sense_d = sense_q;
    case (op)
      OP_RESET: begin
        mode_d  = MODE_RUN;
        sense_d = 1'b0;
      end
      OP_SLEEP: mode_d  = MODE_NAP;
      OP_WAKE:  mode_d  = MODE_RUN;
      OP_SENSE: sense_d = 1'b1;
      OP_CHAN:  sense_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RUN;
      sense_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      sense_q <= sense_d;
    end
  end

  assign asleep   = (mode_q == MODE_NAP);
  assign sense_on = sense_q;
endmodule

// File: rtl/afe_offset_bank.sv
module afe_offset_bank #(
  parameter int NUM_CH = 8,
  parameter int OFS_W  = 11,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_idx,
  input  logic [OFS_W-1:0] wr_code,
  input  logic [CH_W-1:0]  act_idx,
  input  logic [CH_W-1:0]  rd_idx,
  output logic [OFS_W-1:0] act_code,
  output logic [OFS_W-1:0] rd_code
);
  logic [OFS_W-1:0] slot [NUM_CH];

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      logic [OFS_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (clear)
          q <= '0;
        else if (wr_en && wr_idx == CH_W'(g))
          q <= wr_code;
      end
      assign slot[g] = q;
    end
  endgenerate

  assign act_code = slot[act_idx];
  assign rd_code  = slot[rd_idx];
endmodule

// File: rtl/afe_cmd_ctrl.sv
module afe_cmd_ctrl
  import afe_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 11,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [7:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CH_W-1:0]   ch_sel,
  output logic [GAIN_W-1:0] gain_code,
  output logic [OFS_W-1:0]  ofs_code,
  output logic              ldo_sel,
  output logic              ldo_en,
  output logic              sense_sel,
  output logic              pwr_down
);
  localparam int LDO_W = 2;

  cmd_t              dec;
  logic              asleep;
  logic              sense_on;
  logic [GAIN_W-1:0] gain_q;
  logic [LDO_W-1:0]  ldo_q;
  logic [CH_W-1:0]   ch_q;
  logic [CH_W-1:0]   rd_idx;
  logic              rd_is_ofs;
  logic [OFS_W-1:0]  rd_ofs;

  assign cmd_ready = 1'b1;

  afe_cmd_decode i_decode (
    .cmd_fire (cmd_valid & cmd_ready),
    .cmd_addr (cmd_addr),
    .asleep   (asleep),
    .dec      (dec)
  );

  afe_mode_fsm i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (dec.op),
    .asleep   (asleep),
    .sense_on (sense_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      ldo_q  <= '0;
      ch_q   <= '0;
    end else begin
      case (dec.op)
        OP_RESET: begin
          gain_q <= '0;
          ldo_q  <= '0;
          ch_q   <= '0;
        end
        OP_GAIN: gain_q <= cmd_data[GAIN_W-1:0];
        OP_LDO:  ldo_q  <= cmd_data[LDO_W-1:0];
        OP_CHAN: ch_q   <= dec.idx;
        default: ;
      endcase
    end
  end

  afe_offset_bank #(.NUM_CH(NUM_CH), .OFS_W(OFS_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (dec.op == OP_RESET),
    .wr_en    (dec.op == OP_OFS),
    .wr_idx   (dec.idx),
    .wr_code  (cmd_data[OFS_W-1:0]),
    .act_idx  (ch_q),
    .rd_idx   (rd_idx),
    .act_code (ofs_code),
    .rd_code  (rd_ofs)
  );

  always_comb begin
    rd_idx    = '0;
    rd_is_ofs = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == ofs_code_addr(i)) begin
        rd_idx    = CH_W'(i);
        rd_is_ofs = 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_is_ofs)
      rd_data = DATA_W'(rd_ofs);
    else begin
      case (rd_addr)
        SA_ID:   rd_data = DATA_W'(ID_WORD);
        SA_VER:  rd_data = DATA_W'({4'h0, HW_REV, SW_REV});
        SA_GAIN: rd_data = DATA_W'(gain_q);
        SA_LDO:  rd_data = DATA_W'(ldo_q);
        default: rd_data = '0;
      endcase
    end
  end

  assign ch_sel    = ch_q;
  assign gain_code = gain_q;
  assign ldo_sel   = ldo_q[0];
  assign ldo_en    = !asleep || !ldo_q[1];
  assign sense_sel = sense_on;
  assign pwr_down  = asleep;
endmodule

// File: rtl/afe_cmd_ctrl_chk.sv
module afe_cmd_ctrl_chk
  import afe_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 11,
  parameter int GAIN_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic [CH_W-1:0]   ch_sel,
  input logic [GAIN_W-1:0] gain_code,
  input logic [OFS_W-1:0]  ofs_code,
  input logic              ldo_sel,
  input logic              ldo_en,
  input logic              sense_sel,
  input logic              pwr_down
);
  logic is_chan;
  always_comb begin
    is_chan = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if (cmd_addr == chan_code(i)) is_chan = 1'b1;
  end

  a_r11_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_ready);

  a_r6_ldo_on_active: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |-> ldo_en);

  a_r8_chan_ends_sense: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !pwr_down && is_chan) |=> !sense_sel);

  a_r5_gain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !pwr_down && cmd_addr == SA_GAIN)
      |=> gain_code == $past(cmd_data[GAIN_W-1:0]));

  a_r7_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && pwr_down && cmd_addr != SA_WAKE)
      |=> pwr_down && $stable(ch_sel) && $stable(gain_code)
          && $stable(sense_sel) && $stable(ofs_code));

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(ch_sel) && $stable(gain_code) && $stable(ofs_code)
        && $stable(ldo_sel) && $stable(ldo_en) && $stable(sense_sel)
        && $stable(pwr_down));
endmodule

bind afe_cmd_ctrl afe_cmd_ctrl_chk #(
  .DATA_W(DATA_W), .OFS_W(OFS_W), .GAIN_W(GAIN_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data),
  .ch_sel    (ch_sel),
  .gain_code (gain_code),
  .ofs_code  (ofs_code),
  .ldo_sel   (ldo_sel),
  .ldo_en    (ldo_en),
  .sense_sel (sense_sel),
  .pwr_down  (pwr_down)
);

// File: tb/test_afe_cmd_ctrl.sv
module test_afe_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  ch_sel;
  logic [2:0]  gain_code;
  logic [10:0] ofs_code;
  logic        ldo_sel, ldo_en, sense_sel, pwr_down;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model of the register state, built from the requirements
  logic [2:0]  m_ch;
  logic [2:0]  m_gain;
  logic [1:0]  m_ldo;
  logic        m_sleep;
  logic        m_sense;
  logic [10:0] m_ofs [8];

  always #5 clk = ~clk;

  afe_cmd_ctrl i_afe_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ch_sel(ch_sel), .gain_code(gain_code),
    .ofs_code(ofs_code), .ldo_sel(ldo_sel), .ldo_en(ldo_en),
    .sense_sel(sense_sel), .pwr_down(pwr_down)
  );

  function automatic logic [7:0] sel_addr(input int k);
    logic [7:0] t [8] = '{8'h10, 8'h12, 8'h14, 8'h15, 8'h18, 8'h1A, 8'h1C, 8'h1E};
    return t[k];
  endfunction

  function automatic logic [15:0] exp_rd(input logic [7:0] a);
    for (int k = 0; k < 8; k++)
      if (a == sel_addr(k) + 8'h10) return {5'b0, m_ofs[k]};
    case (a)
      8'h02: return 16'h8910;
      8'h03: return 16'h0001;
      8'h06: return {13'b0, m_gain};
      8'h07: return {14'b0, m_ldo};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    m_ch = 0; m_gain = 0; m_ldo = 0; m_sleep = 0; m_sense = 0;
    for (int k = 0; k < 8; k++) m_ofs[k] = '0;
  endtask

  task automatic model_apply(input logic [7:0] a, input logic [15:0] d);
    if (m_sleep) begin
      if (a == 8'h04) m_sleep = 0;
      else if (a == 8'h07) m_ldo = d[1:0];
      return;
    end
    case (a)
      8'h01: model_reset();
      8'h05: m_sleep = 1;
      8'h06: m_gain = d[2:0];
      8'h07: m_ldo = d[1:0];
      8'h08: m_sense = 1;
      default: ;
    endcase
    for (int k = 0; k < 8; k++) begin
      if (a == sel_addr(k)) begin m_ch = 3'(k); m_sense = 0; end
      if (a == sel_addr(k) + 8'h10) m_ofs[k] = d[10:0];
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " ch_sel"},    32'(ch_sel),    32'(m_ch));
    chk({tag, " gain_code"}, 32'(gain_code), 32'(m_gain));
    chk({tag, " R4 ofs_code"}, 32'(ofs_code), 32'(m_ofs[m_ch]));
    chk({tag, " R6 ldo_sel"},  32'(ldo_sel),  32'(m_ldo[0]));
    chk({tag, " R6 ldo_en"},   32'(ldo_en),   32'(!m_sleep || !m_ldo[1]));
    chk({tag, " sense_sel"}, 32'(sense_sel), 32'(m_sense));
    chk({tag, " pwr_down"},  32'(pwr_down),  32'(m_sleep));
    chk({tag, " R11 cmd_ready"}, 32'(cmd_ready), 32'd1);
  endtask

  task automatic check_read(input string tag, input logic [7:0] a);
    rd_addr = a;
    #1;
    chk($sformatf("%s read 0x%02h", tag, a), 32'(rd_data), 32'(exp_rd(a)));
  endtask

  task automatic send(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = 8'hEE; cmd_data = 16'hDEAD;
    model_apply(a, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 reset");
    for (int a = 0; a < 256; a++) check_read("R1 R9 reset", 8'(a));

    // R12: NOP and idle cycles
    send(8'h00, 16'hFFFF);
    check_outs("R12 nop");
    repeat (3) @(negedge clk);
    check_outs("R12 idle");

    // R3: offsets with junk upper bits
    for (int k = 0; k < 8; k++)
      send(sel_addr(k) + 8'h10, 16'(k * 16'h0123 + 16'hF805));
    for (int k = 0; k < 8; k++) check_read("R3 offset", sel_addr(k) + 8'h10);

    // R2, R4: channel sweep
    for (int k = 7; k >= 0; k--) begin
      send(sel_addr(k), 16'hFFFF);
      check_outs("R2 R4 select");
    end
    send(8'h16, 16'h0000); check_outs("R2 unused 0x16");
    send(8'h11, 16'h0000); check_outs("R2 unused 0x11");
    send(8'h1F, 16'h0000); check_outs("R2 unused 0x1F");

    // R4: rewrite active channel offset changes ofs_code
    send(sel_addr(3), 16'h0);
    send(sel_addr(3) + 8'h10, 16'h0489);
    check_outs("R4 live update");

    // R5: gain sweep
    for (int g = 0; g < 8; g++) begin
      send(8'h06, 16'(16'hABC0 | g));
      check_outs("R5 gain");
      check_read("R5 gain", 8'h06);
    end

    // R8: current sense
    send(8'h08, 16'h0); check_outs("R8 sense on");
    send(8'h06, 16'h2); check_outs("R8 sense kept");
    send(sel_addr(5), 16'h0); check_outs("R8 sense cleared");

    // R6: regulator settings, active and sleep
    for (int v = 0; v < 4; v++) begin
      send(8'h07, 16'(16'hFFFC | v));
      check_outs("R6 ldo active");
      check_read("R6 ldo", 8'h07);
      send(8'h05, 16'h0);
      check_outs("R6 R7 ldo sleep");
      send(8'h07, 16'(3 - v));
      check_outs("R6 R7 ldo write in sleep");
      check_read("R6 ldo sleep", 8'h07);
      send(8'h04, 16'h0);
      check_outs("R7 wake");
    end

    // R7, R8: sleep filter over every low sub-address
    send(8'h08, 16'h0);
    send(8'h05, 16'h0);
    check_outs("R7 enter sleep");
    for (int a = 0; a < 64; a++) begin
      if (a == 4 || a == 7) continue;
      send(8'(a), 16'hFFFF);
      check_outs("R7 R8 ignored in sleep");
    end
    for (int a = 0; a < 256; a++) check_read("R7 R9 sleep", 8'(a));
    send(8'h04, 16'h0);
    check_outs("R7 wake keeps sense");

    // R11: read and write in the same cycle
    @(negedge clk);
    rd_addr = 8'h06;
    cmd_valid = 1'b1; cmd_addr = 8'h06; cmd_data = 16'h0005;
    #1;
    chk("R11 same-cycle read old", 32'(rd_data), 32'(m_gain));
    @(negedge clk);
    cmd_valid = 1'b0;
    model_apply(8'h06, 16'h0005);
    #1;
    chk("R11 same-cycle read new", 32'(rd_data), 32'd5);

    // R10: soft reset
    send(8'h07, 16'h3);
    send(8'h01, 16'hFFFF);
    check_outs("R10 soft reset");
    for (int a = 0; a < 256; a++) check_read("R10 after reset", 8'(a));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule